// File: doc/BRIEF.md
# Resynchronizing Serial Byte Receiver

This block receives asynchronous serial frames made of one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line is oversampled by a strobe from an external rate generator. A start bit is confirmed at its centre, and each data and stop bit is sampled at its centre. A good frame delivers its byte with a one-cycle strobe. A frame whose stop sample is low delivers only an error strobe.

What sets this receiver apart is how it recovers from an error. After a bad stop sample it does nothing until it sees the line high. From that moment any low level is taken as a new start bit. A transmitter can rely on this rule. It sends a run of 0x55 bytes and then the four bytes 0x44, 0x11, 0x45, 0x15. Each of these four bytes puts a low level where a misaligned receiver expects its stop bit. The resulting errors walk the receiver from any even bit offset onto the true byte boundary. A tail detector raises an `aligned` flag once that four-byte sequence has been received clean.

Top module: `uart_resync_rx`

## Requirements
- R1: While reset is high and right after it is released, `rx_valid`, `rx_ferr` and `rx_aligned` are low.
- R2: A frame with a high stop sample gives a one-clock pulse on `rx_valid`. In that pulse `rx_byte` carries the byte, with the first data bit on the line placed in bit 0 and the last in bit 7. `rx_byte` holds that value until the next good frame.
- R3: A low level counts as a start bit only if the line is still low half a bit period later. A shorter low pulse produces no strobe of either kind.
- R4: A frame with a low stop sample gives a one-clock pulse on `rx_ferr`, no `rx_valid` pulse, and leaves `rx_byte` unchanged.
- R5: After an error the receiver waits for a high line sample and then treats the next low level as a start bit. A line held low for many bit times therefore gives exactly one error and no byte, and a good frame that follows one high bit period is received correctly.
- R6: `rx_aligned` goes high once the good bytes 0x44, 0x11, 0x45 and 0x15 arrive back to back, with no error in between.
- R7: Any good byte that breaks the sequence (0x55 included) restarts the match. A breaking byte equal to 0x44 counts as the first byte of a new match.
- R8: Once high, `rx_aligned` stays high across any number of other good bytes and drops after the next error.
- R9: A continuous stream is made of 0x55 bytes, then the four-byte sequence twice, then a data byte. The receiver picks this stream up at an offset of 0, 2, 4, 6 or 8 bit times into the first frame. In every case it ends with `rx_aligned` high and the data byte received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversample strobe, OVS pulses per bit period |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| rx_byte | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-clock strobe for a good byte |
| rx_ferr | output | 1 | One-clock strobe for a bad stop sample |
| rx_aligned | output | 1 | Boundary-recovery sequence received clean |

## Verification
An error and a completed tail can meet on the same frame. The bench sends 0x44, 0x11 and 0x45 clean and then 0x15 with a low stop bit, so the tail's last byte and the error arrive together. The error must win: one `rx_ferr` pulse and `rx_aligned` still low. A second overlap is an error frame followed one bit later by a new start. Here the search for a start begins while the error is still being reported. It is judged by the next byte arriving intact.

// File: rtl/uart_resync_pkg.sv
package uart_resync_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_HUNT
   } rx_state_t;

   localparam int TAIL_LEN = 4;

   function automatic logic [7:0] tail_byte(input int idx);
      case (idx)
         0:       return 8'h44;
         1:       return 8'h11;
         2:       return 8'h45;
         default: return 8'h15;
      endcase
   endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic line_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("rx_line_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign line_o = line_i;
   end else if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
         if (rst) q <= 1'b1;
         else     q <= line_i;
      end
      assign line_o = q;
   end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) q <= '1;
         else     q <= {q[STAGES-2:0], line_i};
      end
      assign line_o = q[STAGES-1];
   end

endmodule

// File: rtl/rx_frame_core.sv
module rx_frame_core
   import uart_resync_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rx,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              ferr_o
);

   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("rx_frame_core: OVS must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("rx_frame_core: DATA_W must be at least 2");
   end

   rx_state_t          state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [BIT_W-1:0]   bit_q;
   logic [DATA_W-1:0]  shift_q;
   logic [DATA_W-1:0]  data_q;
   logic               valid_q;
   logic               ferr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         shift_q <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         if (tick) begin
            case (state_q)
               RX_IDLE: begin
                  if (!rx) begin
                     state_q <= RX_START;
                     cnt_q   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == CNT_HALF) begin
                     cnt_q   <= '0;
                     bit_q   <= '0;
                     state_q <= rx ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q   <= '0;
                     shift_q <= {rx, shift_q[DATA_W-1:1]};
                     if (bit_q == BIT_LAST) state_q <= RX_STOP;
                     else                   bit_q   <= bit_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q <= '0;
                     if (rx) begin
                        valid_q <= 1'b1;
                        data_q  <= shift_q;
                        state_q <= RX_IDLE;
                     end else begin
                        ferr_q  <= 1'b1;
                        state_q <= RX_HUNT;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_HUNT: begin
                  if (rx) state_q <= RX_IDLE;
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;
   assign ferr_o  = ferr_q;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(valid_q && ferr_q)); // R4
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      valid_q |=> !valid_q); // R2
   AST_FERR_PULSE: assert property (@(posedge clk) disable iff (rst)
      ferr_q |=> !ferr_q); // R4
   AST_FERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
      ferr_q |-> $stable(data_q)); // R4
   AST_HUNT_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
      (state_q == RX_HUNT && tick && !rx) |=> state_q == RX_HUNT); // R5
   AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state_q == RX_START && tick && cnt_q == CNT_HALF && rx) |=> state_q == RX_IDLE); // R3

endmodule

// File: rtl/rx_tail_match.sv
module rx_tail_match
   import uart_resync_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic              ferr_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic              aligned_o
);

   localparam int IDX_W = $clog2(TAIL_LEN);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TAIL_LEN - 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("rx_tail_match: tail sequence is defined for 8-bit bytes");
   end

   logic [IDX_W-1:0]  idx_q;
   logic              aligned_q;
   logic [DATA_W-1:0] want;

   always_comb want = tail_byte(int'(idx_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q     <= '0;
         aligned_q <= 1'b0;
      end else if (ferr_i) begin
         idx_q     <= '0;
         aligned_q <= 1'b0;
      end else if (valid_i) begin
         if (byte_i == want) begin
            if (idx_q == IDX_LAST) begin
               idx_q     <= '0;
               aligned_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end else if (byte_i == tail_byte(0)) begin
            idx_q <= IDX_W'(1);
         end else begin
            idx_q <= '0;
         end
      end
   end

   assign aligned_o = aligned_q;

   AST_ALIGN_DROPS: assert property (@(posedge clk) disable iff (rst)
      ferr_i |=> !aligned_q); // R8
   AST_ALIGN_RISE_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
      $rose(aligned_q) |-> $past(valid_i)); // R6
   AST_ALIGN_FALL_ON_ERR: assert property (@(posedge clk) disable iff (rst)
      $fell(aligned_q) |-> $past(ferr_i)); // R8

endmodule

// File: rtl/uart_resync_rx.sv
module uart_resync_rx
   import uart_resync_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              os_tick,
   input  logic              rxd_in,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              rx_ferr,
   output logic              rx_aligned
);

   logic rx_line;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .line_i (rxd_in),
      .line_o (rx_line)
   );

   rx_frame_core #(.OVS(OVS), .DATA_W(DATA_W)) u_core (
      .clk     (clk),
      .rst     (rst),
      .tick    (os_tick),
      .rx      (rx_line),
      .data_o  (rx_byte),
      .valid_o (rx_valid),
      .ferr_o  (rx_ferr)
   );

   rx_tail_match #(.DATA_W(DATA_W)) u_tail (
      .clk       (clk),
      .rst       (rst),
      .valid_i   (rx_valid),
      .ferr_i    (rx_ferr),
      .byte_i    (rx_byte),
      .aligned_o (rx_aligned)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!rx_valid && !rx_ferr && !rx_aligned)); // R1

endmodule

// File: tb/uart_resync_rx_bench.sv
module uart_resync_rx_bench;

   localparam int OVS      = 16;
   localparam int TICK_DIV = 2;
   localparam int BIT_CLK  = OVS * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_valid, rx_ferr, rx_aligned;

   int total = 0;
   int bad   = 0;
   int nrx   = 0;
   int nferr = 0;
   logic [7:0] last_rx = 8'h00;
   int tdiv = 0;

   logic       stream [0:255];
   int         slen;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      os_tick <= (tdiv == TICK_DIV - 1);
   end

   uart_resync_rx u_uart_resync_rx (
      .clk(clk), .rst(rst), .os_tick(os_tick), .rxd_in(rxd),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
      .rx_aligned(rx_aligned)
   );

   always @(negedge clk) begin
      if (!rst && rx_valid) begin
         nrx     <= nrx + 1;
         last_rx <= rx_byte;
      end
      if (!rst && rx_ferr) nferr <= nferr + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int clocks);
      rxd = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      hold_line(1'b0, BIT_CLK);
      for (int i = 0; i < 8; i++) hold_line(b[i], BIT_CLK);
      hold_line(stop, BIT_CLK);
   endtask

   task automatic add_frame(input logic [7:0] b);
      stream[slen] = 1'b0; slen++;
      for (int i = 0; i < 8; i++) begin stream[slen] = b[i]; slen++; end
      stream[slen] = 1'b1; slen++;
   endtask

   task automatic do_reset();
      rxd = 1'b1;
      @(negedge clk); rst = 1'b1;
      repeat (6) @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [7:0] tail(input int i);
      case (i)
         0: return 8'h44;
         1: return 8'h11;
         2: return 8'h45;
         default: return 8'h15;
      endcase
   endfunction

   task automatic good_byte(input logic [7:0] b, input string req);
      int n0;
      n0 = nrx;
      send_frame(b, 1'b1);
      hold_line(1'b1, 4);
      check(nrx == n0 + 1 && last_rx == b, req, last_rx, b);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n0, f0;
      logic [7:0] b;
      void'($urandom(32'd1234));

      repeat (5) @(negedge clk);
      check(!rx_valid && !rx_ferr && !rx_aligned, "R1 during reset", {rx_valid, rx_ferr, rx_aligned}, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      check(!rx_valid && !rx_ferr && !rx_aligned, "R1 after reset", {rx_valid, rx_ferr, rx_aligned}, 0);
      hold_line(1'b1, 2 * BIT_CLK);

      // R2 directed patterns, LSB first
      good_byte(8'h00, "R2 zero byte");
      good_byte(8'hFF, "R2 ones byte");
      good_byte(8'h01, "R2 bit0 first");
      good_byte(8'h80, "R2 bit7 last");
      // R2 random bytes with random idle gaps, including back to back
      for (int i = 0; i < 16; i++) begin
         b = 8'($urandom);
         good_byte(b, "R2 random byte");
         hold_line(1'b1, BIT_CLK * int'($urandom % 3));
      end

      // R4 bad stop bit
      n0 = nrx; f0 = nferr;
      send_frame(8'h3C, 1'b0);
      hold_line(1'b1, BIT_CLK);
      check(nferr == f0 + 1, "R4 error pulse", nferr - f0, 1);
      check(nrx == n0, "R4 no valid", nrx - n0, 0);
      check(rx_byte == last_rx, "R4 byte kept", rx_byte, last_rx);
      // R5 immediate hunt after one high bit
      good_byte(8'h96, "R5 byte after error");

      // R5 long break gives one error only
      n0 = nrx; f0 = nferr;
      hold_line(1'b0, 30 * BIT_CLK);
      hold_line(1'b1, BIT_CLK);
      check(nferr == f0 + 1 && nrx == n0, "R5 break single error", nferr - f0, 1);
      good_byte(8'h5A, "R5 byte after break");

      // R3 false starts
      n0 = nrx; f0 = nferr;
      hold_line(1'b0, (OVS / 4) * TICK_DIV);
      hold_line(1'b1, 2 * BIT_CLK);
      hold_line(1'b0, (OVS / 2 - 2) * TICK_DIV);
      hold_line(1'b1, 2 * BIT_CLK);
      check(nrx == n0 && nferr == f0, "R3 glitch ignored", (nrx - n0) + (nferr - f0), 0);
      good_byte(8'hC3, "R3 byte after glitch");

      // R6 / R7 / R8 tail detector
      do_reset();
      for (int i = 0; i < 3; i++) send_frame(tail(i), 1'b1);
      hold_line(1'b1, 4);
      check(!rx_aligned, "R6 partial tail", rx_aligned, 0);
      send_frame(8'h55, 1'b1);
      send_frame(8'h15, 1'b1);
      hold_line(1'b1, 4);
      check(!rx_aligned, "R7 0x55 restarts match", rx_aligned, 0);
      send_frame(8'h44, 1'b1);
      for (int i = 0; i < 4; i++) send_frame(tail(i), 1'b1);
      hold_line(1'b1, 4);
      check(rx_aligned, "R7 repeated 0x44 then R6 full tail", rx_aligned, 1);
      for (int i = 0; i < 5; i++) send_frame(8'($urandom), 1'b1);
      hold_line(1'b1, 4);
      check(rx_aligned, "R8 held across bytes", rx_aligned, 1);
      send_frame(8'h20, 1'b0);
      hold_line(1'b1, BIT_CLK);
      check(!rx_aligned, "R8 cleared by error", rx_aligned, 0);

      // error and tail completion on the same frame
      f0 = nferr;
      for (int i = 0; i < 3; i++) send_frame(tail(i), 1'b1);
      send_frame(8'h15, 1'b0);
      hold_line(1'b1, BIT_CLK);
      check(!rx_aligned && nferr == f0 + 1, "R6 error on last tail byte", rx_aligned, 0);

      // R9 recovery from every even offset
      for (int k = 0; k <= 8; k += 2) begin
         b = 8'($urandom);
         slen = 0;
         for (int i = 0; i < 3; i++) add_frame(8'h55);
         for (int r = 0; r < 2; r++)
            for (int i = 0; i < 4; i++) add_frame(tail(i));
         add_frame(b);
         do_reset();
         hold_line(1'b1, 2 * BIT_CLK);
         for (int i = k; i < slen; i++) hold_line(stream[i], BIT_CLK);
         hold_line(1'b1, 2 * BIT_CLK);
         check(rx_aligned, $sformatf("R9 aligned offset %0d", k), rx_aligned, 1);
         check(last_rx == b, $sformatf("R9 data offset %0d", k), last_rx, b);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule